// File: doc/BRIEF.md
# Auto-Increment Packet Data Port

This block gives a host byte-wide access to packet page memory. The host never addresses the memory directly. Instead it loads a 16-bit pointer register one byte at a time. The pointer holds three things: a byte offset within a 2048-byte page, a flag that picks which page is used, and a flag that turns on auto-increment. The host then reads or writes through a four-byte data window. Every data-window access becomes exactly one access on a synchronous memory port, at the address `{page, offset}`.

The page comes from one of two inputs. One is the page number at the head of the receive queue. The other is a packet number that the host has written into a neighbouring register. When auto-increment is on, each data access advances the offset by one, wrapping inside the 11-bit field. This lets the host stream a packet through any window byte. When auto-increment is off, the pointer holds still. The low two address bits of the window are added to the offset, so the host can reach four neighbouring bytes without rewriting the pointer.

All host reads return their byte one cycle after the read strobe, together with a valid strobe. This holds whether the byte comes from the pointer or from memory. A 16-bit host transfer is made as two byte accesses, low byte first.

Top module: `pdp_data_port`

## Requirements
- R1: After reset the pointer is zero, no memory access is issued and the read-valid strobe is low; reading the pointer bytes returns 0x00 for both.
- R2: A write at host offset 0 sets pointer bits 7:0 and a write at host offset 1 sets pointer bits 15:8, each leaving the other byte unchanged. A read at offset 0 returns bits 7:0. A read at offset 1 returns bits 15:8 ANDed with 0xF7, so pointer bit 11 always reads as 0.
- R3: A data access uses the receive-queue head page when pointer bit 15 is 1, and the packet-number page when it is 0. The page forms the upper bits of the memory address.
- R4: A host access at offsets 4 to 7 (the data window) drives exactly one memory access in the same cycle, at address `{page, 11-bit offset}`. A write sets the write enable and passes the host byte through. A read clears the write enable.
- R5: When pointer bit 14 is 1, the access uses offset `ptr[10:0]` alone. After every data access, read or write, `ptr[10:0]` becomes `(ptr[10:0] + 1) mod 2048` and bits 15:11 are unchanged.
- R6: When pointer bit 14 is 0, the pointer does not change on a data access. The access uses offset `(ptr[10:0] + host_addr[1:0]) mod 2048`.
- R7: A read strobe without a write strobe raises read-valid in the next cycle and in no other. For a data-window read, the byte then returned is the one the memory returns for that access.
- R8: When write and read strobes are high together, only the write takes place and read-valid stays low in the next cycle. Writes at offsets 2, 3 and 8 to 15 change neither the pointer nor memory. Reads at those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host byte write strobe |
| hst_rd | input | 1 | Host byte read strobe |
| hst_addr | input | 4 | Host byte offset within the register bank |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, valid with hst_rvalid |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read |
| rxq_head_pg | input | PG_W | Page number at the head of the receive queue |
| pkt_num_pg | input | PG_W | Page number from the packet-number register |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PG_W+11 | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after mem_en |

## Verification
The bound checker watches several rules on every cycle. Memory is touched only for data-window strobes, and a write strobe always wins. The page bits follow pointer bit 15. The offset steps by exactly one, with the upper pointer bits frozen, whenever auto-increment is on. The pointer holds still for fixed-mode accesses and for writes to unused offsets. Read-valid follows each lone read strobe by one cycle. Other behaviour only the bench scenarios can show, because it depends on values carried through memory or on specific pointer contents. This covers the 0xF7 readback mask and the sum of the window's low bits, including its wrap past offset 2047. It also covers the increment wrapping from 2047 to 0, and bytes written in one mode and read back in another.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam int PTR_W     = 16;
  localparam int OFS_W     = 11;
  localparam int RXSEL_BIT = 15;
  localparam int AUTO_BIT  = 14;
  localparam int HA_W      = 4;
  localparam logic [7:0] HI_VIEW_MASK = 8'hF7;
  localparam logic [HA_W-1:0] ADR_PTR_LO = 4'd0;
  localparam logic [HA_W-1:0] ADR_PTR_HI = 4'd1;
  localparam logic [HA_W-3:0] ADR_WIN_QUAD = 2'd1;

  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [OFS_W-1:0] ofs_t;

  function automatic logic is_window(input logic [HA_W-1:0] a);
    return a[HA_W-1:2] == ADR_WIN_QUAD;
  endfunction

  function automatic ptr_t step_ptr(input ptr_t p);
    ptr_t r;
    r = p;
    r[OFS_W-1:0] = p[OFS_W-1:0] + ofs_t'(1);
    return r;
  endfunction

  function automatic ofs_t access_ofs(input ptr_t p, input logic [1:0] lo2);
    if (p[AUTO_BIT]) return p[OFS_W-1:0];
    return p[OFS_W-1:0] + ofs_t'(lo2);
  endfunction

  function automatic logic [7:0] hi_view(input ptr_t p);
    return p[PTR_W-1:8] & HI_VIEW_MASK;
  endfunction
endpackage

// File: rtl/pdp_ptr_reg.sv
module pdp_ptr_reg
  import pdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wdata,
  input  logic       step,
  output ptr_t       ptr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (wr_lo) begin
      ptr_q[7:0] <= wdata;
    end else if (wr_hi) begin
      ptr_q[PTR_W-1:8] <= wdata;
    end else if (step) begin
      ptr_q <= step_ptr(ptr_q);
    end
  end
endmodule

// File: rtl/pdp_addr_gen.sv
module pdp_addr_gen
  import pdp_pkg::*;
#(
  parameter int PG_W = 2,
  localparam int MA_W = PG_W + OFS_W
)(
  input  ptr_t            ptr,
  input  logic [1:0]      lo2,
  input  logic [PG_W-1:0] rxq_pg,
  input  logic [PG_W-1:0] pkt_pg,
  output logic [MA_W-1:0] addr
);
  logic [PG_W-1:0] pg;
  ofs_t            ofs;

  always_comb begin
    pg   = ptr[RXSEL_BIT] ? rxq_pg : pkt_pg;
    ofs  = access_ofs(ptr, lo2);
    addr = {pg, ofs};
  end
endmodule

// File: rtl/pdp_rd_ret.sv
module pdp_rd_ret (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_fire,
  input  logic       from_mem,
  input  logic [7:0] local_byte,
  input  logic [7:0] mem_rdata,
  output logic [7:0] rdata,
  output logic       rvalid
);
  logic       mem_sel_q;
  logic [7:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid    <= 1'b0;
      mem_sel_q <= 1'b0;
      hold_q    <= '0;
    end else begin
      rvalid <= rd_fire;
      if (rd_fire) begin
        mem_sel_q <= from_mem;
        hold_q    <= local_byte;
      end
    end
  end

  always_comb begin
    if (!rvalid)        rdata = '0;
    else if (mem_sel_q) rdata = mem_rdata;
    else                rdata = hold_q;
  end
endmodule

// File: rtl/pdp_data_port.sv
module pdp_data_port
  import pdp_pkg::*;
#(
  parameter int PG_W = 2,
  localparam int MA_W = PG_W + OFS_W
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hst_wr,
  input  logic            hst_rd,
  input  logic [3:0]      hst_addr,
  input  logic [7:0]      hst_wdata,
  output logic [7:0]      hst_rdata,
  output logic            hst_rvalid,
  input  logic [PG_W-1:0] rxq_head_pg,
  input  logic [PG_W-1:0] pkt_num_pg,
  output logic            mem_en,
  output logic            mem_we,
  output logic [MA_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata
);
  // named internal events, visible to the bound checker
  logic       rd_fire;
  logic       win_hit;
  logic       data_fire;
  logic       wr_lo;
  logic       wr_hi;
  logic       step;
  logic [7:0] local_byte;
  ptr_t       ptr_q;

  always_comb begin
    win_hit   = is_window(hst_addr);
    rd_fire   = hst_rd & ~hst_wr;
    data_fire = (hst_wr | rd_fire) & win_hit;
    wr_lo     = hst_wr & (hst_addr == ADR_PTR_LO);
    wr_hi     = hst_wr & (hst_addr == ADR_PTR_HI);
    step      = data_fire & ptr_q[AUTO_BIT];
    unique case (hst_addr)
      ADR_PTR_LO: local_byte = ptr_q[7:0];
      ADR_PTR_HI: local_byte = hi_view(ptr_q);
      default:    local_byte = 8'h00;
    endcase
  end

  pdp_ptr_reg u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (hst_wdata),
    .step  (step),
    .ptr_q (ptr_q)
  );

  pdp_addr_gen #(.PG_W(PG_W)) u_agen (
    .ptr    (ptr_q),
    .lo2    (hst_addr[1:0]),
    .rxq_pg (rxq_head_pg),
    .pkt_pg (pkt_num_pg),
    .addr   (mem_addr)
  );

  pdp_rd_ret u_ret (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire    (rd_fire),
    .from_mem   (win_hit),
    .local_byte (local_byte),
    .mem_rdata  (mem_rdata),
    .rdata      (hst_rdata),
    .rvalid     (hst_rvalid)
  );

  assign mem_en    = data_fire;
  assign mem_we    = hst_wr & win_hit;
  assign mem_wdata = hst_wdata;
endmodule

// File: rtl/pdp_data_port_chk.sv
module pdp_data_port_chk
  import pdp_pkg::*;
#(
  parameter int PG_W = 2,
  localparam int MA_W = PG_W + OFS_W
)(
  input logic            clk,
  input logic            rst_n,
  input logic            hst_wr,
  input logic            hst_rd,
  input logic [3:0]      hst_addr,
  input logic            hst_rvalid,
  input logic [PG_W-1:0] rxq_head_pg,
  input logic [PG_W-1:0] pkt_num_pg,
  input logic            mem_en,
  input logic            mem_we,
  input logic [MA_W-1:0] mem_addr,
  input logic            data_fire,
  input ptr_t            ptr_q
);
  // R7
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_wr) |=> hst_rvalid);

  // R8
  no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_rd && !hst_wr) |=> !hst_rvalid);

  // R4
  mem_only_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ((hst_wr || hst_rd) && hst_addr[3:2] == 2'b01));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && hst_wr) |-> mem_we);

  // R3
  page_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[MA_W-1:OFS_W] == (ptr_q[15] ? rxq_head_pg : pkt_num_pg)));

  // R5
  auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && ptr_q[14]) |=>
      (ptr_q[10:0] == $past(ptr_q[10:0]) + 11'd1) && (ptr_q[15:11] == $past(ptr_q[15:11])));

  // R6
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && !ptr_q[14]) |=> $stable(ptr_q));

  // R8
  unused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_addr[3:1] != 3'b000 && hst_addr[3:2] != 2'b01) |=> $stable(ptr_q));
endmodule

bind pdp_data_port pdp_data_port_chk #(.PG_W(PG_W)) u_chk (.*);

// File: tb/test_pdp_data_port.sv
module test_pdp_data_port;
  localparam int PG_W = 2;
  localparam int MA_W = PG_W + 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            hst_wr = 1'b0, hst_rd = 1'b0;
  logic [3:0]      hst_addr = '0;
  logic [7:0]      hst_wdata = '0;
  logic [7:0]      hst_rdata;
  logic            hst_rvalid;
  logic [PG_W-1:0] rxq_head_pg = '0, pkt_num_pg = '0;
  logic            mem_en, mem_we;
  logic [MA_W-1:0] mem_addr;
  logic [7:0]      mem_wdata;
  logic [7:0]      mem_rdata = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // captured per strobe
  logic            c_en, c_we;
  logic [MA_W-1:0] c_addr;
  logic [7:0]      c_wdata;
  logic            r_valid;
  logic [7:0]      r_data;

  logic [7:0] model [int];

  always #2 clk = ~clk;

  pdp_data_port #(.PG_W(PG_W)) i_pdp_data_port (.*);

  // synchronous memory: one cycle read latency
  always @(posedge clk) begin
    if (mem_en && mem_we) model[int'(mem_addr)] = mem_wdata;
    else if (mem_en) mem_rdata <= model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input bit rd, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_wr = wr; hst_rd = rd; hst_addr = a; hst_wdata = d;
    #1;
    c_en = mem_en; c_we = mem_we; c_addr = mem_addr; c_wdata = mem_wdata;
    @(posedge clk);
    #1;
    r_valid = hst_rvalid; r_data = hst_rdata;
    hst_wr = 1'b0; hst_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] v);
    bus(1, 0, 4'd0, v[7:0]);
    bus(1, 0, 4'd1, v[15:8]);
  endtask

  task automatic read_at(input logic [3:0] a, output logic [7:0] v, output logic vld);
    bus(0, 1, a, 8'h00);
    vld = r_valid;
    v = r_data;
  endtask

  function automatic int exp_addr(input int pg, input int ofs);
    return pg * 2048 + (ofs % 2048);
  endfunction

  task automatic t_reset;
    logic [7:0] v; logic vld;
    chk(hst_rvalid == 0, "R1 rvalid after reset", hst_rvalid, 0);
    chk(mem_en == 0, "R1 mem idle after reset", mem_en, 0);
    read_at(4'd0, v, vld);
    chk(vld && v == 8'h00, "R1 ptr low reset", v, 0);
    read_at(4'd1, v, vld);
    chk(vld && v == 8'h00, "R1 ptr high reset", v, 0);
  endtask

  task automatic t_ptr_bytes;
    logic [7:0] v; logic vld;
    bus(1, 0, 4'd0, 8'h5A);
    read_at(4'd1, v, vld);
    chk(v == 8'h00, "R2 high untouched by low write", v, 0);
    bus(1, 0, 4'd1, 8'hFF);
    read_at(4'd1, v, vld);
    chk(vld && v == 8'hF7, "R2 high readback mask", v, 8'hF7);
    read_at(4'd0, v, vld);
    chk(vld && v == 8'h5A, "R2 low kept", v, 8'h5A);
  endtask

  task automatic t_fixed;
    logic [7:0] v; logic vld;
    pkt_num_pg = 2'd2; rxq_head_pg = 2'd1;
    set_ptr(16'h0123);
    bus(1, 0, 4'd6, 8'hA7);
    chk(c_en && c_we && c_wdata == 8'hA7, "R4 window write strobes", {c_en, c_we}, 3);
    chk(int'(c_addr) == exp_addr(2, 'h123 + 2), "R6 offset plus low bits", c_addr, exp_addr(2, 'h125));
    read_at(4'd0, v, vld);
    chk(v == 8'h23, "R6 pointer held low", v, 8'h23);
    read_at(4'd1, v, vld);
    chk(v == 8'h01, "R6 pointer held high", v, 8'h01);
    set_ptr(16'h07FF);
    bus(0, 1, 4'd7, 8'h00);
    chk(c_en && !c_we, "R4 window read strobes", {c_en, c_we}, 2);
    chk(int'(c_addr) == exp_addr(2, 'h7FF + 3), "R6 sum wraps", c_addr, exp_addr(2, 2));
  endtask

  task automatic t_rxsel;
    set_ptr(16'h8010);
    bus(1, 0, 4'd4, 8'hC3);
    chk(int'(c_addr) == exp_addr(1, 'h10), "R3 receive head page", c_addr, exp_addr(1, 'h10));
    bus(0, 1, 4'd4, 8'h00);
    chk(r_valid && r_data == 8'hC3, "R7 read returns memory byte", r_data, 8'hC3);
    rxq_head_pg = 2'd3;
    bus(0, 1, 4'd4, 8'h00);
    chk(int'(c_addr) == exp_addr(3, 'h10), "R3 follows head input", c_addr, exp_addr(3, 'h10));
    set_ptr(16'h0010);
    bus(0, 1, 4'd4, 8'h00);
    chk(int'(c_addr) == exp_addr(2, 'h10), "R3 packet number page", c_addr, exp_addr(2, 'h10));
  endtask

  task automatic t_auto;
    logic [7:0] v; logic vld;
    pkt_num_pg = 2'd0;
    set_ptr(16'h47FE);
    bus(1, 0, 4'd5, 8'h11);
    chk(int'(c_addr) == exp_addr(0, 'h7FE), "R5 low bits not added", c_addr, exp_addr(0, 'h7FE));
    bus(1, 0, 4'd4, 8'h22);
    chk(int'(c_addr) == exp_addr(0, 'h7FF), "R5 step after write", c_addr, exp_addr(0, 'h7FF));
    bus(1, 0, 4'd7, 8'h33);
    chk(int'(c_addr) == exp_addr(0, 0), "R5 offset wraps to zero", c_addr, 0);
    read_at(4'd1, v, vld);
    chk(v == (8'h40 & 8'hF7), "R5 upper bits unchanged", v, 8'h40);
    read_at(4'd0, v, vld);
    chk(v == 8'h01, "R5 offset after three steps", v, 1);
    set_ptr(16'h47FE);
    read_at(4'd4, v, vld);
    chk(vld && v == 8'h11, "R5 read stream byte 0", v, 8'h11);
    read_at(4'd6, v, vld);
    chk(vld && v == 8'h22, "R5 read stream byte 1", v, 8'h22);
    read_at(4'd0, v, vld);
    chk(v == 8'h00, "R5 reads advance offset", v, 0);
  endtask

  task automatic t_collide_ignored;
    logic [7:0] v; logic vld;
    set_ptr(16'h4100);
    bus(1, 1, 4'd4, 8'h66);
    chk(c_we && !r_valid, "R8 write wins, no rvalid", {c_we, r_valid}, 2);
    read_at(4'd0, v, vld);
    chk(v == 8'h01, "R8 single step on collision", v, 1);
    bus(1, 0, 4'd2, 8'hEE);
    chk(!c_en, "R8 offset 2 write no memory", c_en, 0);
    bus(1, 0, 4'd9, 8'hEE);
    chk(!c_en, "R8 offset 9 write no memory", c_en, 0);
    bus(1, 0, 4'd15, 8'hEE);
    read_at(4'd0, v, vld);
    chk(v == 8'h01, "R8 pointer low unchanged", v, 1);
    read_at(4'd1, v, vld);
    chk(v == 8'h41, "R8 pointer high unchanged", v, 8'h41);
    read_at(4'd3, v, vld);
    chk(vld && v == 8'h00, "R8 unused read returns zero", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr_bytes();
    t_fixed();
    t_rxsel();
    t_auto();
    t_collide_ignored();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule